// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR flash array that is built from several 16-bit lanes sharing one address bus. It takes two kinds of request from a user port: write one word, or clear a range of blocks. For each request it drives the flash's command interface in the proper order. It polls the status word until every lane reports ready and puts the array back into read mode. It then reports the result with a one-cycle `done` pulse and a two-bit result code.

The flash is split into two erase regions. The low region holds small blocks and the upper region holds large blocks. A range request is checked against the block size of the region where each of its end points falls. The block then walks block by block, and the step grows when the walk crosses into the large-block region. A word write is confirmed by reading the word back after the device reports completion. A programmable cycle limit ends polling on a device that never becomes ready.

Top module: `nor_op_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `fl_wr` and `fl_rd` are low.
- R2: A word write issues a bus write of the program-setup command to the word address, then a bus write of the data word to the same address. A command is driven into every 16-bit lane as 0x00cc, so program setup is 0x0040 per lane.
- R3: A block clear issues a bus write of erase setup (0x0020 per lane), then erase confirm (0x00D0 per lane), both at the block base address.
- R4: Each poll iteration writes the status command (0x0070 per lane), drives `fl_rd` for one cycle, and takes `fl_rdata` on the following cycle. Polling ends only when bit 7 of every 16-bit lane is 1.
- R5: When polling ends, the read-array command (0x00FF per lane) is written to the same address before any result is reported.
- R6: A word write reports result 2 if bit 4 of any lane is set in the final status. Otherwise the word is read back, and the result is 2 on a mismatch and 0 on a match.
- R7: A block clear fails with result 2 if bit 5 of any lane is set in the final status. A range stops at the first failing block and issues nothing for later blocks.
- R8: A range is rejected with result 2'd1 and no bus activity in any of these cases: its length is zero; start plus length exceeds the device size; the start is not a multiple of the block size of its region; the end is not a multiple of the block size of its region. A point equal to the first address of the large region belongs to that region, and an end equal to the device size is valid.
- R9: A range advances by the block size of the region the current address lies in: 8 words below word 32 and 32 words from word 32 up, with default parameters. It finishes with result 0 after its last block.
- R10: A word write to an address at or beyond the device size (160 words by default) is rejected with result 1 and no bus activity.
- R11: A poll cycle counter starts at 0 in the first status-command cycle and counts up by one in every polling cycle. If a status sample shows a lane not ready and the counter is at or above `poll_limit`, polling stops, read-array is written, and the result is 2.
- R12: `done` lasts exactly one cycle, with `busy` low in that cycle, and `result` is 0, 1 or 2. A rejected request completes in the cycle after it is taken.
- R13: There is no flash bus activity while `busy` is low, and `fl_wr` and `fl_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_erase | input | 1 | 1 selects block clear of a range, 0 selects word write |
| req_addr | input | AW | Word address, or first word of the range |
| req_len | input | AW | Range length in words (block clear only) |
| req_data | input | LANES*16 | Word to write |
| poll_limit | input | TW | Polling cycle limit |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 bad request, 2 device failure |
| fl_wr | output | 1 | Flash bus write strobe |
| fl_rd | output | 1 | Flash bus read strobe |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | LANES*16 | Flash write data |
| fl_rdata | input | LANES*16 | Flash read data, valid the cycle after `fl_rd` |

## Verification
The assertions assume that `req_valid` is raised only while `busy` is low. They also assume the flash returns read data exactly one cycle after `fl_rd`, and that the region boundary is a multiple of the large block size. The stimulus keeps to these assumptions: each request waits for the previous `done` before it is issued. The flash model registers its read data on the edge that samples `fl_rd`, and the default geometry puts the boundary at one large block. Status and error behaviour, including one lane finishing before the other and a device that never becomes ready, comes from per-lane busy counters and error flags in the model.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int LANE_W = 16;

    // Command bytes, placed in the low byte of every lane
    localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS   = 8'h70;
    localparam logic [7:0] CMD_PROG_SETUP    = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP   = 8'h20;
    localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;

    // Status bit positions inside one lane
    localparam int STS_READY_BIT = 7;
    localparam int STS_ERASE_BIT = 5;
    localparam int STS_PROG_BIT  = 4;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_SETUP    = 4'd1,
        ST_SECOND   = 4'd2,
        ST_POLL_CMD = 4'd3,
        ST_POLL_RD  = 4'd4,
        ST_POLL_CAP = 4'd5,
        ST_RESTORE  = 4'd6,
        ST_VER_RD   = 4'd7,
        ST_VER_CAP  = 4'd8
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_BAD_REQ  = 2'd1,
        RES_DEV_FAIL = 2'd2
    } result_e;

endpackage

// File: rtl/nor_region_map.sv
// Returns the erase block size, in words, of the region holding a point.
module nor_region_map #(
    parameter int AW        = 16,
    parameter int SMALL_LOG = 3,
    parameter int SMALL_CNT = 4,
    parameter int BIG_LOG   = 5
) (
    input  logic [AW:0] point,
    output logic [AW:0] blk_words
);
    localparam int          BOUNDARY_I = SMALL_CNT * (2 ** SMALL_LOG);
    localparam logic [AW:0] BOUNDARY   = (AW + 1)'(BOUNDARY_I);
    localparam logic [AW:0] SMALL_W    = (AW + 1)'(2 ** SMALL_LOG);
    localparam logic [AW:0] BIG_W      = (AW + 1)'(2 ** BIG_LOG);

    always_comb begin
        blk_words = (point >= BOUNDARY) ? BIG_W : SMALL_W;
    end
endmodule

// File: rtl/nor_poll_timer.sv
// Saturating cycle counter used to bound status polling.
module nor_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/nor_op_sequencer.sv
module nor_op_sequencer
    import nor_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LANES     = 2,
    parameter int TW        = 16,
    parameter int SMALL_LOG = 3,
    parameter int SMALL_CNT = 4,
    parameter int BIG_LOG   = 5,
    parameter int BIG_CNT   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_erase,
    input  logic [AW-1:0]           req_addr,
    input  logic [AW-1:0]           req_len,
    input  logic [LANES*LANE_W-1:0] req_data,
    input  logic [TW-1:0]           poll_limit,
    output logic                    busy,
    output logic                    done,
    output logic [1:0]              result,
    output logic                    fl_wr,
    output logic                    fl_rd,
    output logic [AW-1:0]           fl_addr,
    output logic [LANES*LANE_W-1:0] fl_wdata,
    input  logic [LANES*LANE_W-1:0] fl_rdata
);
    localparam int          DW        = LANES * LANE_W;
    localparam int          DEV_I     = SMALL_CNT * (2 ** SMALL_LOG) + BIG_CNT * (2 ** BIG_LOG);
    localparam logic [AW:0] DEV_WORDS = (AW + 1)'(DEV_I);

    typedef struct packed {
        seq_state_e     state;
        logic           erase;
        logic [AW-1:0]  addr;
        logic [AW:0]    remain;
        logic [DW-1:0]  wdata;
        logic           fail;
        logic           done;
        result_e        result;
    } seq_regs_t;

    seq_regs_t q, d;

    function automatic logic [DW-1:0] lane_cmd(input logic [7:0] c);
        return {LANES{{{(LANE_W - 8){1'b0}}, c}}};
    endfunction

    // Per-lane status flags
    logic [LANES-1:0] lane_ready, lane_erase_err, lane_prog_err;
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ready[g]     = fl_rdata[g*LANE_W + STS_READY_BIT];
        assign lane_erase_err[g] = fl_rdata[g*LANE_W + STS_ERASE_BIT];
        assign lane_prog_err[g]  = fl_rdata[g*LANE_W + STS_PROG_BIT];
    end
    logic all_ready, any_erase_err, any_prog_err;
    assign all_ready     = &lane_ready;
    assign any_erase_err = |lane_erase_err;
    assign any_prog_err  = |lane_prog_err;

    // Region lookups for range start, range end and the walking address
    logic [AW:0] start_pt, end_pt, walk_pt;
    logic [AW:0] start_blk, end_blk, walk_blk;
    assign start_pt = {1'b0, req_addr};
    assign end_pt   = {1'b0, req_addr} + {1'b0, req_len};
    assign walk_pt  = {1'b0, q.addr};

    nor_region_map #(.AW(AW), .SMALL_LOG(SMALL_LOG), .SMALL_CNT(SMALL_CNT), .BIG_LOG(BIG_LOG))
        u_map_start (.point(start_pt), .blk_words(start_blk));
    nor_region_map #(.AW(AW), .SMALL_LOG(SMALL_LOG), .SMALL_CNT(SMALL_CNT), .BIG_LOG(BIG_LOG))
        u_map_end   (.point(end_pt),   .blk_words(end_blk));
    nor_region_map #(.AW(AW), .SMALL_LOG(SMALL_LOG), .SMALL_CNT(SMALL_CNT), .BIG_LOG(BIG_LOG))
        u_map_walk  (.point(walk_pt),  .blk_words(walk_blk));

    logic start_ok, end_ok, range_bad, prog_bad;
    assign start_ok  = ((start_pt & (start_blk - 1'b1)) == '0);
    assign end_ok    = ((end_pt & (end_blk - 1'b1)) == '0);
    assign range_bad = (req_len == '0) || (end_pt > DEV_WORDS) || !start_ok || !end_ok;
    assign prog_bad  = (start_pt >= DEV_WORDS);

    // Poll timeout
    logic timer_clear, timer_run, timer_expired;
    assign timer_clear = (q.state == ST_SECOND);
    assign timer_run   = (q.state == ST_POLL_CMD) || (q.state == ST_POLL_RD) ||
                         (q.state == ST_POLL_CAP);

    nor_poll_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .run     (timer_run),
        .limit   (poll_limit),
        .expired (timer_expired)
    );

    // Next-state logic
    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.erase  = req_erase;
                    d.addr   = req_addr;
                    d.remain = {1'b0, req_len};
                    d.wdata  = req_data;
                    d.fail   = 1'b0;
                    if (req_erase ? range_bad : prog_bad) begin
                        d.done   = 1'b1;
                        d.result = RES_BAD_REQ;
                    end else begin
                        d.state = ST_SETUP;
                    end
                end
            end
            ST_SETUP:    d.state = ST_SECOND;
            ST_SECOND:   d.state = ST_POLL_CMD;
            ST_POLL_CMD: d.state = ST_POLL_RD;
            ST_POLL_RD:  d.state = ST_POLL_CAP;
            ST_POLL_CAP: begin
                if (all_ready) begin
                    d.fail  = q.erase ? any_erase_err : any_prog_err;
                    d.state = ST_RESTORE;
                end else if (timer_expired) begin
                    d.fail  = 1'b1;
                    d.state = ST_RESTORE;
                end else begin
                    d.state = ST_POLL_CMD;
                end
            end
            ST_RESTORE: begin
                if (q.fail) begin
                    d.state  = ST_IDLE;
                    d.done   = 1'b1;
                    d.result = RES_DEV_FAIL;
                end else if (!q.erase) begin
                    d.state = ST_VER_RD;
                end else if (q.remain <= walk_blk) begin
                    d.state  = ST_IDLE;
                    d.done   = 1'b1;
                    d.result = RES_OK;
                end else begin
                    d.addr   = q.addr + walk_blk[AW-1:0];
                    d.remain = q.remain - walk_blk;
                    d.state  = ST_SETUP;
                end
            end
            ST_VER_RD:  d.state = ST_VER_CAP;
            ST_VER_CAP: begin
                d.state  = ST_IDLE;
                d.done   = 1'b1;
                d.result = (fl_rdata == q.wdata) ? RES_OK : RES_DEV_FAIL;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Flash bus drive
    always_comb begin
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        fl_wdata = '0;
        unique case (q.state)
            ST_SETUP: begin
                fl_wr    = 1'b1;
                fl_wdata = q.erase ? lane_cmd(CMD_ERASE_SETUP) : lane_cmd(CMD_PROG_SETUP);
            end
            ST_SECOND: begin
                fl_wr    = 1'b1;
                fl_wdata = q.erase ? lane_cmd(CMD_ERASE_CONFIRM) : q.wdata;
            end
            ST_POLL_CMD: begin
                fl_wr    = 1'b1;
                fl_wdata = lane_cmd(CMD_READ_STATUS);
            end
            ST_RESTORE: begin
                fl_wr    = 1'b1;
                fl_wdata = lane_cmd(CMD_READ_ARRAY);
            end
            ST_POLL_RD, ST_VER_RD: fl_rd = 1'b1;
            default: ;
        endcase
    end

    assign fl_addr = q.addr;
    assign busy    = (q.state != ST_IDLE);
    assign done    = q.done;
    assign result  = q.result;

endmodule

// File: rtl/nor_seq_checker.sv
module nor_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic       fl_wr,
    input logic       fl_rd
);
    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3));

    // R8
    bad_req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd1) |-> $past(req_valid && !busy));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(fl_wr || fl_rd));

    // R13
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    // R4
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |=> !(fl_wr || fl_rd));
endmodule

bind nor_op_sequencer nor_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .fl_wr     (fl_wr),
    .fl_rd     (fl_rd)
);

// File: tb/tb_nor_op_sequencer.sv
`timescale 1ns/1ps
module tb_nor_op_sequencer;
    localparam int DEV = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [31:0] req_data = '0;
    logic [15:0] poll_limit = 16'd1000;
    logic        busy, done, fl_wr, fl_rd;
    logic [1:0]  result;
    logic [15:0] fl_addr;
    logic [31:0] fl_wdata;
    logic [31:0] fl_rdata = '0;

    always #4 clk = ~clk;

    nor_op_sequencer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
        .poll_limit(poll_limit), .busy(busy), .done(done), .result(result),
        .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    int n_checks = 0;
    int n_fail = 0;
    int n_done = 0;

    typedef struct { logic [15:0] a; logic [31:0] d; string tag; } wr_t;
    typedef struct { logic [1:0] r; string tag; } res_t;
    wr_t  exp_wr[$];
    res_t exp_res[$];

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input logic [7:0] c);
        return {8'h00, c, 8'h00, c};
    endfunction

    function automatic int blk_of(input int a);
        return (a >= 32) ? 32 : 8;
    endfunction

    // Flash model
    logic [31:0] mem [0:DEV-1];
    int          mode = 0;
    int          pend = 0;
    int          busy0 = 0, busy1 = 0;
    logic [7:0]  err0 = 0, err1 = 0;
    int          k0 = 0, k1 = 0;
    logic [31:0] stuck = 0;
    bit          inj_pgm_fail = 0;
    int          erase_fail_base = -1;

    initial for (int i = 0; i < DEV; i++) mem[i] = 32'hFFFF_FFFF;

    always @(posedge clk) begin : model
        int a, sz, base;
        a = int'(fl_addr);
        if (fl_wr) begin
            if (pend == 1) begin
                if (a < DEV) mem[a] = mem[a] & fl_wdata & ~stuck;
                busy0 = k0; busy1 = k1; err0 = 0;
                err1 = inj_pgm_fail ? 8'h10 : 8'h00;
                pend = 0; mode = 1;
            end else if (pend == 2) begin
                if (fl_wdata[7:0] == 8'hD0) begin
                    sz = blk_of(a);
                    base = a - (a % sz);
                    for (int i = 0; i < sz; i++) if (base + i < DEV) mem[base + i] = 32'hFFFF_FFFF;
                    busy0 = k0; busy1 = k1; err0 = 0;
                    err1 = (base == erase_fail_base) ? 8'h20 : 8'h00;
                    mode = 1;
                end
                pend = 0;
            end else begin
                case (fl_wdata[7:0])
                    8'h40: pend = 1;
                    8'h20: pend = 2;
                    8'h70: mode = 1;
                    8'hFF: mode = 0;
                    default: ;
                endcase
            end
        end
        if (fl_rd) begin
            if (mode == 1) begin
                fl_rdata <= {8'h00, (busy1 > 0) ? 8'h00 : (8'h80 | err1),
                             8'h00, (busy0 > 0) ? 8'h00 : (8'h80 | err0)};
                if (busy0 > 0) busy0--;
                if (busy1 > 0) busy1--;
            end else begin
                fl_rdata <= (a < DEV) ? mem[a] : 32'hFFFF_FFFF;
            end
        end
    end

    // Monitor: compares bus writes and completions against the scoreboard
    always @(negedge clk) begin : monitor
        wr_t  e;
        res_t r;
        if (rst_n) begin
            if (fl_wr) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R13", "unexpected bus write", {16'h0, fl_addr, fl_wdata}, 64'h0);
                end else begin
                    e = exp_wr.pop_front();
                    check({fl_addr, fl_wdata} == {e.a, e.d}, e.tag, "bus write addr/data",
                          {16'h0, fl_addr, fl_wdata}, {16'h0, e.a, e.d});
                end
            end
            if (done) begin
                check(!busy, "R12", "busy during done", 64'(busy), 64'h0);
                if (exp_res.size() == 0) begin
                    check(1'b0, "R12", "unexpected done", 64'(result), 64'h0);
                end else begin
                    r = exp_res.pop_front();
                    check(result == r.r, r.tag, "result code", 64'(result), 64'(r.r));
                end
                n_done++;
            end
        end
    end

    task automatic push_wr(int a, logic [31:0] d, string tag);
        wr_t w;
        w.a = a[15:0]; w.d = d; w.tag = tag;
        exp_wr.push_back(w);
    endtask

    task automatic push_res(logic [1:0] code, string tag);
        res_t r;
        r.r = code; r.tag = tag;
        exp_res.push_back(r);
    endtask

    task automatic push_seq(int a, logic [31:0] w1, logic [31:0] w2, int polls, string tag);
        push_wr(a, w1, tag);
        push_wr(a, w2, tag);
        for (int i = 0; i < polls; i++) push_wr(a, cw(8'h70), "R4");
        push_wr(a, cw(8'hFF), "R5");
    endtask

    task automatic fire(bit er, int a, int len, logic [31:0] data);
        int target;
        target = n_done + 1;
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; req_addr = a[15:0]; req_len = len[15:0]; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        wait (n_done >= target);
        @(negedge clk);
    endtask

    task automatic do_program(int a, logic [31:0] data, int polls, logic [1:0] code, string tag);
        push_seq(a, cw(8'h40), data, polls, tag);
        push_res(code, tag);
        fire(1'b0, a, 0, data);
    endtask

    task automatic do_erase(int a, int len, int polls, int fail_base, logic [1:0] code, string tag);
        int cur, rem;
        cur = a; rem = len;
        k0 = polls - 1; k1 = polls - 1;
        erase_fail_base = fail_base;
        while (rem > 0) begin
            push_seq(cur, cw(8'h20), cw(8'hD0), polls, tag);
            if (cur == fail_base) break;
            rem -= blk_of(cur);
            cur += blk_of(cur);
        end
        push_res(code, tag);
        fire(1'b1, a, len, 32'h0);
        erase_fail_base = -1;
    endtask

    task automatic do_bad(bit er, int a, int len, string tag);
        push_res(2'd1, tag);
        fire(er, a, len, 32'hDEAD_BEEF);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    initial begin : stim
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fl_wr && !fl_rd, "R1", "outputs in reset",
              {60'h0, busy, done, fl_wr, fl_rd}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fl_wr && !fl_rd, "R1", "outputs after reset",
              {60'h0, busy, done, fl_wr, fl_rd}, 64'h0);

        // R2 R4 R5 R6: plain word write, both lanes busy for two reads
        k0 = 2; k1 = 2;
        do_program(5, 32'h1234_5678, 3, 2'd0, "R2");
        // R4: lane 1 becomes ready later than lane 0
        k0 = 0; k1 = 3;
        do_program(6, 32'hA5A5_0F0F, 4, 2'd0, "R4");
        // R6: program error flag in one lane
        k0 = 1; k1 = 1; inj_pgm_fail = 1;
        do_program(7, 32'h0000_00FF, 2, 2'd2, "R6");
        inj_pgm_fail = 0;
        // R6: read-back mismatch
        stuck = 32'h0000_0001;
        do_program(8, 32'hFFFF_FFFF, 2, 2'd2, "R6");
        stuck = 0;
        // R3 R9: one small block, then the cleared word programs cleanly
        do_erase(8, 8, 2, -1, 2'd0, "R3");
        k0 = 0; k1 = 0;
        do_program(8, 32'h0000_1111, 1, 2'd0, "R3");
        // R9: range crossing into the large-block region
        do_erase(24, 72, 1, -1, 2'd0, "R9");
        // R7: failure on the first large block stops the walk
        do_erase(16, 48, 1, 32, 2'd2, "R7");
        // R8: rejected ranges
        do_bad(1'b1, 8, 0, "R8");
        do_bad(1'b1, 128, 64, "R8");
        do_bad(1'b1, 36, 28, "R8");
        do_bad(1'b1, 8, 32, "R8");
        do_bad(1'b1, 4, 4, "R8");
        // R8: accepted edges (end on region start, end on device size)
        do_erase(24, 8, 1, -1, 2'd0, "R8");
        do_erase(128, 32, 1, -1, 2'd0, "R8");
        // R10: word write beyond the device
        do_bad(1'b0, 160, 0, "R10");
        // R11: device never ready, limits 20 and 4
        k0 = 1000; k1 = 1000;
        poll_limit = 16'd20;
        do_program(50, 32'h0000_0001, (20 + 3) / 3, 2'd2, "R11");
        poll_limit = 16'd4;
        do_program(51, 32'h0000_0002, (4 + 3) / 3, 2'd2, "R11");
        poll_limit = 16'd1000;

        repeat (4) @(negedge clk);
        check(exp_wr.size() == 0, "R13", "pending expected writes", 64'(exp_wr.size()), 64'h0);
        check(exp_res.size() == 0, "R12", "pending expected results", 64'(exp_res.size()), 64'h0);
        check(!busy, "R12", "busy at end", 64'(busy), 64'h0);
        finish_run();
    end
endmodule